// File: doc/BRIEF.md
# Modem Control and Status Tracker with Loopback

This block keeps the 5-bit modem control register of a 16550-style serial port and derives the modem status register from it. When the loop bit is set, each control output is fed back to one status input. When the loop bit is clear, the status inputs are held at fixed values that keep a terminal driver from blocking. After every control write the block compares the new status with the old status. It sets sticky change bits, and these bits stay set until software reads the status register. The read returns the value and clears the change bits.

The register bus has separate read and write strobes, each with its own address. A read at the status address in the same cycle as a control write is allowed. A change caused by that write is not lost to the clear. The block raises a modem-status interrupt request while any change bit is set and the external enable is high.

The link-mode state machine has two states. `MODE_NORMAL` is the reset state. Transition ENTER_LOOP moves it to `MODE_LOOP` on a control write with bit 4 set. Transition LEAVE_LOOP moves it back on a control write with bit 4 clear. The change-tracking state machine also has two states. `EV_QUIET` is the reset state. Transition EV_RAISE moves it to `EV_HELD` when any change bit becomes set. Transition EV_DROP moves it back when all change bits are clear again.

Top module: `mdm_loop_tracker`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xA0 and `msi_req` is low.
- R2: A control write stores only bits 4:0: DTR bit 0, RTS bit 1, OUT1 bit 2, OUT2 bit 3, LOOP bit 4. Bits 7:5 of a control read are always 0.
- R3: With LOOP set, status bit 4 (CTS) equals RTS, bit 5 (DSR) equals DTR, bit 6 (RI) equals OUT1 and bit 7 (DCD) equals OUT2.
- R4: With LOOP clear, status bits 7:4 read 1,0,1,0 (DCD and DSR high, RI and CTS low), whatever the other control bits hold.
- R5: On a control write, change bit 0 (CTS), change bit 1 (DSR) and change bit 3 (DCD) are set when the matching status bit toggles.
- R6: Change bit 2 (RI trailing edge) is set only when RI goes from 1 to 0. A rising RI never sets it.
- R7: Change bits accumulate over several control writes until they are cleared.
- R8: A status read returns the current value in `rd_data` one cycle after the strobe, and the read clears all four change bits.
- R9: Writes to the status address or to an unmapped address change nothing. Reads of an unmapped address return 0x00.
- R10: A change event from a control write in the same cycle as a status read survives the clear.
- R11: `msi_req` is high exactly when some change bit is set and `msi_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write register offset |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read register offset |
| rd_data | output | 8 | Read data, registered, valid the cycle after `rd_en` |
| msi_en | input | 1 | Modem-status interrupt enable |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that reset is held low for at least one clock edge before any strobe. They also assume that `wr_en` and `rd_en` are driven to known values at every edge, because the past-value checks on read data and on the change bits depend on those strobes. The bench meets both conditions. It holds reset through several edges and drives every strobe from tasks on the falling edge. It deasserts each strobe one cycle later, so no check ever sees an unknown or overlapping stimulus. Only the same-cycle read-and-write test overlaps the two strobes, and it does so on purpose.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int DATA_W = 8;
    localparam int CTL_W  = 5;

    // control bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // change bit positions inside the status low nibble
    localparam int D_CTS  = 0;
    localparam int D_DSR  = 1;
    localparam int D_RI   = 2;
    localparam int D_DCD  = 3;

    // status high nibble, MSB first: dcd(7) ri(6) dsr(5) cts(4)
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    typedef enum logic [0:0] {MODE_NORMAL = 1'b0, MODE_LOOP = 1'b1} link_mode_e;
    typedef enum logic [0:0] {EV_QUIET = 1'b0, EV_HELD = 1'b1} ev_state_e;

    function automatic line_t derive_lines(input logic [CTL_W-1:0] ctl);
        line_t l;
        if (ctl[C_LOOP]) begin
            l.cts = ctl[C_RTS];
            l.dsr = ctl[C_DTR];
            l.ri  = ctl[C_OUT1];
            l.dcd = ctl[C_OUT2];
        end else begin
            l.cts = 1'b0;
            l.dsr = 1'b1;
            l.ri  = 1'b0;
            l.dcd = 1'b1;
        end
        return l;
    endfunction
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_upd,
    input  logic [CTL_W-1:0] ctl_in,
    output logic [CTL_W-1:0] ctl_q,
    output link_mode_e       mode_q
);
    link_mode_e mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            mode_q <= MODE_NORMAL;
        end else begin
            if (ctl_upd) ctl_q <= ctl_in;
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: if (ctl_upd && ctl_in[C_LOOP])  mode_d = MODE_LOOP;    // ENTER_LOOP
            MODE_LOOP:   if (ctl_upd && !ctl_in[C_LOOP]) mode_d = MODE_NORMAL;  // LEAVE_LOOP
        endcase
    end

    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_upd) |-> $stable(ctl_q))
        else $error("control register changed without a control write");

    assert_mode_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_upd) |-> ((mode_q == MODE_LOOP) == $past(ctl_in[C_LOOP])))
        else $error("link mode does not follow loop bit");
endmodule

// File: rtl/mdm_sts_track.sv
module mdm_sts_track
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_upd,
    input  logic [CTL_W-1:0] ctl_in,
    input  logic             clr,
    output line_t            lines_q,
    output logic [3:0]       delta_q,
    output ev_state_e        ev_q
);
    line_t      lines_new;
    logic [3:0] evt;
    logic [3:0] delta_d;
    ev_state_e  ev_d;

    assign lines_new = derive_lines(ctl_in);

    always_comb begin
        evt = '0;
        if (ctl_upd) begin
            evt[D_CTS] = lines_new.cts ^ lines_q.cts;
            evt[D_DSR] = lines_new.dsr ^ lines_q.dsr;
            evt[D_DCD] = lines_new.dcd ^ lines_q.dcd;
            evt[D_RI]  = lines_q.ri & ~lines_new.ri;
        end
        delta_d = (clr ? 4'b0 : delta_q) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= derive_lines('0);
            delta_q <= '0;
            ev_q    <= EV_QUIET;
        end else begin
            if (ctl_upd) lines_q <= lines_new;
            delta_q <= delta_d;
            ev_q    <= ev_d;
        end
    end

    always_comb begin
        ev_d = ev_q;
        unique case (ev_q)
            EV_QUIET: if (|delta_d)  ev_d = EV_HELD;   // EV_RAISE
            EV_HELD:  if (!(|delta_d)) ev_d = EV_QUIET; // EV_DROP
        endcase
    end

    assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[D_RI]) |-> ($past(lines_q.ri) && !lines_q.ri))
        else $error("RI change bit without falling RI");

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(delta_q != 4'b0) && !$past(clr)) |-> ((delta_q & $past(delta_q)) == $past(delta_q)))
        else $error("change bit lost without a read");

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr) && !$past(ctl_upd)) |-> (delta_q == 4'b0))
        else $error("change bits survive a read");
endmodule

// File: rtl/mdm_loop_tracker.sv
module mdm_loop_tracker
    import mdm_pkg::*;
#(
    parameter int              ADDR_W   = 3,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 3'd4,
    parameter logic [ADDR_W-1:0] STS_ADDR = 3'd6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              msi_en,
    output logic              msi_req
);
    localparam int PAD_W = DATA_W - CTL_W;

    logic             ctl_upd;
    logic             sts_rd;
    logic [CTL_W-1:0] ctl_q;
    link_mode_e       mode_q;
    line_t            lines_q;
    logic [3:0]       delta_q;
    ev_state_e        ev_q;
    logic [7:0]       sts_val;
    logic             unused_hi;

    assign ctl_upd   = wr_en && (wr_addr == CTL_ADDR);
    assign sts_rd    = rd_en && (rd_addr == STS_ADDR);
    assign unused_hi = ^wr_data[DATA_W-1:CTL_W];

    mdm_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_upd (ctl_upd),
        .ctl_in  (wr_data[CTL_W-1:0]),
        .ctl_q   (ctl_q),
        .mode_q  (mode_q)
    );

    mdm_sts_track u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_upd (ctl_upd),
        .ctl_in  (wr_data[CTL_W-1:0]),
        .clr     (sts_rd),
        .lines_q (lines_q),
        .delta_q (delta_q),
        .ev_q    (ev_q)
    );

    assign sts_val = {lines_q, delta_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == CTL_ADDR)      rd_data <= {{PAD_W{1'b0}}, ctl_q};
            else if (rd_addr == STS_ADDR) rd_data <= sts_val;
            else                          rd_data <= '0;
        end
    end

    assign msi_req = (ev_q == EV_HELD) && msi_en;

    assert_ctl_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && $past(rd_addr) == CTL_ADDR) |-> (rd_data[7:5] == 3'b000))
        else $error("control read shows upper bits");

    assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOOP) |-> (lines_q.cts == ctl_q[C_RTS] && lines_q.dsr == ctl_q[C_DTR] &&
                                   lines_q.ri == ctl_q[C_OUT1] && lines_q.dcd == ctl_q[C_OUT2]))
        else $error("loopback mapping broken");

    assert_normal_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL) |-> (sts_val[7:4] == 4'b1010))
        else $error("normal-mode status wrong");

    assert_read_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sts_rd) |-> (rd_data == $past(sts_val)))
        else $error("status read data wrong");

    assert_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> (msi_en && delta_q != 4'b0))
        else $error("request without cause");
endmodule

// File: tb/test_mdm_loop_tracker.sv
module test_mdm_loop_tracker;
    localparam logic [2:0] A_CTL = 3'd4;
    localparam logic [2:0] A_STS = 3'd6;
    localparam logic [2:0] A_NONE = 3'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, msi_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       msi_req;
    int n_chk = 0, n_fail = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    mdm_loop_tracker i_mdm_loop_tracker (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .msi_en(msi_en), .msi_req(msi_req)
    );

    function automatic logic [3:0] lines_of(input logic [4:0] c);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return 4'b1010;
    endfunction

    function automatic logic [3:0] evt_of(input logic [3:0] o, input logic [3:0] n);
        // nibble order dcd ri dsr cts; change order dcd(3) ri(2) dsr(1) cts(0)
        return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {7'b0, msi_req}, 8'h00);
        rd(A_CTL, got); check("R1 ctl", got, 8'h00);
        rd(A_STS, got); check("R1 sts", got, 8'hA0);

        // R2 masking over all write values
        for (int v = 0; v < 256; v++) begin
            wr(A_CTL, v[7:0]);
            rd(A_CTL, got); check("R2 ctl readback", got, {3'b000, v[4:0]});
        end
        wr(A_CTL, 8'h00);
        rd(A_STS, got);

        // R3 R4 R5 R6 R11: all ordered pairs of control values
        msi_en = 1'b1;
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [3:0] la, lb, ev;
                la = lines_of(a[4:0]); lb = lines_of(b[4:0]); ev = evt_of(la, lb);
                wr(A_CTL, {3'b000, a[4:0]});
                rd(A_STS, got);
                check("R3 R4 lines after first write", {got[7:4], 4'h0}, {la, 4'h0});
                wr(A_CTL, {3'b000, b[4:0]});
                check("R11 irq", {7'b0, msi_req}, {7'b0, |ev});
                rd(A_STS, got);
                check("R5 R6 change bits", got, {lb, ev});
                check("R11 irq after clear", {7'b0, msi_req}, 8'h00);
            end
        end

        // R7 accumulation: loop 0x10, then RTS, then DTR, no reads between
        wr(A_CTL, 8'h10); rd(A_STS, got);
        wr(A_CTL, 8'h12);
        wr(A_CTL, 8'h13);
        rd(A_STS, got); check("R7 sticky", got, 8'h33);
        rd(A_STS, got); check("R8 cleared", got, 8'h30);

        // R11 disable
        wr(A_CTL, 8'h10);
        msi_en = 1'b0;
        @(negedge clk); check("R11 masked", {7'b0, msi_req}, 8'h00);
        msi_en = 1'b1;
        @(negedge clk); check("R11 enabled", {7'b0, msi_req}, 8'h01);
        rd(A_STS, got); check("R8 read value", got, 8'h03);

        // R9 ignored writes and unmapped reads
        wr(A_STS, 8'hFF);
        rd(A_STS, got); check("R9 sts write ignored", got, 8'h00);
        wr(A_NONE, 8'h1F);
        rd(A_CTL, got); check("R9 unmapped write ignored", got, 8'h10);
        rd(A_NONE, got); check("R9 unmapped read", got, 8'h00);

        // R10 same-cycle read and event (0x10 -> 0x12 sets CTS change)
        wr(A_CTL, 8'h00); rd(A_STS, got);
        wr(A_CTL, 8'h10);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = A_STS; wr_en = 1'b1; wr_addr = A_CTL; wr_data = 8'h12;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 old value read", rd_data, 8'h0A);
        rd(A_STS, got); check("R10 new change survives", got, 8'h11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule